// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast clock by a programmable integer and emits one single-cycle pulse per output period. It models a two-modulus prescaler that divides by either ten or eleven. The prescaler feeds a main counter, and a swallow counter sets how many prescaler periods per output period use the longer modulus. With the prescaler active, the division ratio is ten times (M+1) plus A. A bypass control takes the prescaler out of the path. Each input clock then advances the main counter directly, and the ratio becomes M+1.

The prescaler is synthesizable logic clocked by the same fast clock. The block also exposes two monitoring outputs: the prescaler output as a pulse train, and the modulus-select level. A hardwired-configuration input clears the two most significant bits of M, as happens when the value comes straight from pins. M, A and bypass are sampled only at the boundary between two output periods, so a period that is already running always completes with the settings it started with.

Top module: `pulse_swallow_div`

## Requirements
- R1: With `preBypass` low, consecutive `divOut` pulses are exactly 10*(M+1)+A clock cycles apart, for legal settings 1 <= M <= 511 and A <= min(15, M+1).
- R2: With `preBypass` high, consecutive `divOut` pulses are exactly M+1 cycles apart, and the value of `aSet` has no effect.
- R3: `divOut` is high for exactly one clock cycle per output period.
- R4: With the prescaler active, `modSel` is high (divide by eleven) during the first A prescaler periods of each output period and low for the rest. It is therefore high for 11*A clock cycles per output period. In bypass it stays low.
- R5: `presOut` pulses high for one cycle at the end of each prescaler period, which gives exactly M+1 pulses per output period (one per clock in bypass).
- R6: Settings are captured only at an output-period boundary. A change made partway through a period leaves that period's length unchanged, and the new ratio applies from the next period.
- R7: While `hardWired` is high, bits 8 and 7 of M are treated as zero.
- R8: While `rstN` is low, all outputs are low. The first output period starts at the first clock edge after reset is released, so the first `divOut` pulse is visible ratio+1 cycles after the release.
- R9: The smallest legal M (1) gives a ratio of 2 in bypass and 20+A with the prescaler active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rstN | input | 1 | Active-low asynchronous reset |
| mSet | input | 9 | Main counter setting M |
| aSet | input | 4 | Swallow count A |
| preBypass | input | 1 | High: prescaler bypassed. Low: prescaler active |
| hardWired | input | 1 | High: M bits 8 and 7 are forced to zero |
| divOut | output | 1 | One-cycle pulse per output period |
| presOut | output | 1 | One-cycle pulse per prescaler period (monitor) |
| modSel | output | 1 | High while the prescaler divides by eleven (monitor) |

## Verification
A wrong prescaler count, swallow count or main count changes the spacing of `divOut` pulses within the very next output period. Measuring that spacing in clock cycles therefore points directly at the faulty term of the ratio formula. The same measurement window also counts the cycles in which `modSel` is high, which isolates the swallow counter, and counts `presOut` pulses, which isolates the main counter. A settings register that reloads at the wrong time shows up as a transition period whose length is neither the old ratio nor the new one. Such a period appears within one output period of the change.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // Strobes from the sequencing control to the counter datapath
  typedef struct packed {
    logic load;  // capture settings and restart both counters
    logic tick;  // prescaler period ends: advance main counter
    logic adv;   // advance prescaler counter
  } stepCtl_t;
endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int A_W      = 4,
  parameter int PRE_LO   = 10,
  parameter int FORCE_HI = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  stepCtl_t       step,
  input  logic [M_W-1:0] mSet,
  input  logic [A_W-1:0] aSet,
  input  logic           preBypass,
  input  logic           hardWired,
  output logic           psLast,
  output logic           mLast,
  output logic           curByp,
  output logic           modSel,
  output logic [M_W-1:0] curM,
  output logic [$clog2(PRE_LO+1)-1:0] psCnt
);
  localparam int PS_W = $clog2(PRE_LO + 1);
  localparam logic [PS_W-1:0] LAST_LO = PS_W'(PRE_LO - 1);
  localparam logic [PS_W-1:0] LAST_HI = PS_W'(PRE_LO);

  logic [M_W-1:0] mLoad;
  logic [M_W-1:0] mCnt;
  logic [A_W-1:0] curA;

  // Top bits of M are cleared in hardwired configuration
  for (genvar i = 0; i < M_W; i++) begin : g_mask
    if (i >= M_W - FORCE_HI) begin : g_hi
      assign mLoad[i] = mSet[i] & ~hardWired;
    end else begin : g_lo
      assign mLoad[i] = mSet[i];
    end
  end

  always_comb begin
    modSel = !curByp && (M_W'(curA) > mCnt);
    psLast = (psCnt == (modSel ? LAST_HI : LAST_LO));
    mLast  = (mCnt == curM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curM   <= '0;
      curA   <= '0;
      curByp <= 1'b0;
      mCnt   <= '0;
      psCnt  <= '0;
    end else if (step.load) begin
      curM   <= mLoad;
      curA   <= aSet;
      curByp <= preBypass;
      mCnt   <= '0;
      psCnt  <= '0;
    end else if (step.tick) begin
      psCnt <= '0;
      mCnt  <= mCnt + 1'b1;
    end else if (step.adv) begin
      psCnt <= psCnt + 1'b1;
    end
  end
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     psLast,
  input  logic     mLast,
  input  logic     curByp,
  output stepCtl_t step,
  output logic     wrap,
  output logic     primed
);
  always_comb begin
    step.tick = primed && (curByp || psLast);
    wrap      = step.tick && mLast;
    step.load = !primed || wrap;
    step.adv  = primed && !step.tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int A_W      = 4,
  parameter int PRE_LO   = 10,
  parameter int FORCE_HI = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [M_W-1:0] mSet,
  input  logic [A_W-1:0] aSet,
  input  logic           preBypass,
  input  logic           hardWired,
  output logic           divOut,
  output logic           presOut,
  output logic           modSel
);
  localparam int PS_W = $clog2(PRE_LO + 1);

  stepCtl_t       step;
  logic           psLast, mLast, wrap;
  logic           dpCurByp, ctlPrimed;
  logic [M_W-1:0] dpCurM;
  logic [PS_W-1:0] dpPsCnt;

  psd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .psLast(psLast), .mLast(mLast),
    .curByp(dpCurByp), .step(step), .wrap(wrap), .primed(ctlPrimed)
  );

  psd_datapath #(.M_W(M_W), .A_W(A_W), .PRE_LO(PRE_LO), .FORCE_HI(FORCE_HI)) u_dp (
    .clk(clk), .rstN(rstN), .step(step), .mSet(mSet), .aSet(aSet),
    .preBypass(preBypass), .hardWired(hardWired), .psLast(psLast),
    .mLast(mLast), .curByp(dpCurByp), .modSel(modSel), .curM(dpCurM),
    .psCnt(dpPsCnt)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divOut  <= 1'b0;
      presOut <= 1'b0;
    end else begin
      divOut  <= wrap;
      presOut <= step.tick;
    end
  end
endmodule

// File: rtl/psd_chk.sv
module psd_chk #(
  parameter int M_W    = 9,
  parameter int PRE_LO = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           divOut,
  input logic           presOut,
  input logic           modSel,
  input logic           curByp,
  input logic           primed,
  input logic [M_W-1:0] curM,
  input logic [$clog2(PRE_LO+1)-1:0] psCnt
);
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);

  assert_div_on_prescaler_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    divOut |-> presOut);

  assert_modsel_low_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    curByp |-> !modSel);

  assert_modsel_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(primed) && !$stable(modSel)) |-> presOut);

  assert_setting_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(primed) && !divOut) |-> $stable(curM));

  assert_prescaler_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= ($clog2(PRE_LO+1))'(PRE_LO));
endmodule

bind pulse_swallow_div psd_chk #(.M_W(M_W), .PRE_LO(PRE_LO)) u_chk (
  .clk(clk), .rstN(rstN), .divOut(divOut), .presOut(presOut),
  .modSel(modSel), .curByp(dpCurByp), .primed(ctlPrimed),
  .curM(dpCurM), .psCnt(dpPsCnt)
);

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] mSet = 9'd8;
  logic [3:0] aSet = 4'd0;
  logic       preBypass = 1'b0;
  logic       hardWired = 1'b0;
  logic       divOut, presOut, modSel;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_div i_pulse_swallow_div (
    .clk(clk), .rstN(rstN), .mSet(mSet), .aSet(aSet), .preBypass(preBypass),
    .hardWired(hardWired), .divOut(divOut), .presOut(presOut), .modSel(modSel)
  );

  typedef struct packed {
    logic        byp;
    logic        hard;
    logic [8:0]  m;
    logic [3:0]  a;
    logic [15:0] ratio;  // expected clock cycles per output period
    logic [8:0]  mEff;   // M after hardwired masking
    logic [3:0]  aEff;   // swallow count that applies (0 in bypass)
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 9'd8,   4'd0,  16'd90,   9'd8,   4'd0},   // R1 contiguous minimum
    '{1'b0, 1'b0, 9'd8,   4'd9,  16'd99,   9'd8,   4'd9},   // R1 A = M+1
    '{1'b0, 1'b0, 9'd1,   4'd2,  16'd22,   9'd1,   4'd2},   // R9 min M, max A
    '{1'b0, 1'b0, 9'd1,   4'd0,  16'd20,   9'd1,   4'd0},   // R9
    '{1'b0, 1'b0, 9'd20,  4'd15, 16'd225,  9'd20,  4'd15},  // R1
    '{1'b0, 1'b0, 9'd3,   4'd4,  16'd44,   9'd3,   4'd4},   // R1
    '{1'b1, 1'b0, 9'd5,   4'd3,  16'd6,    9'd5,   4'd0},   // R2
    '{1'b1, 1'b0, 9'd1,   4'd0,  16'd2,    9'd1,   4'd0},   // R9 bypass
    '{1'b1, 1'b0, 9'd100, 4'd7,  16'd101,  9'd100, 4'd0},   // R2 A ignored
    '{1'b1, 1'b1, 9'd511, 4'd0,  16'd128,  9'd127, 4'd0},   // R7
    '{1'b0, 1'b1, 9'd389, 4'd3,  16'd63,   9'd5,   4'd3},   // R7
    '{1'b0, 1'b0, 9'd511, 4'd15, 16'd5135, 9'd511, 4'd15},  // R1 max
    '{1'b0, 1'b0, 9'd511, 4'd0,  16'd5120, 9'd511, 4'd0}    // R1 max M
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divOut);
  endtask

  // Measures one full output period starting at a divOut pulse
  task automatic measure(output int per, output int ms, output int ps);
    waitPulse();
    per = 1; ms = int'(modSel); ps = 0;
    while (1) begin
      @(negedge clk);
      ps += int'(presOut);
      if (divOut) break;
      per++;
      ms += int'(modSel);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    int per, ms, ps, cnt;
    // R8: outputs low under reset
    repeat (4) begin
      @(negedge clk);
      check(!divOut && !presOut && !modSel, "R8 reset outputs",
            int'({divOut, presOut, modSel}), 0);
    end
    // R8: first pulse ratio+1 cycles after release (M=8, A=0 -> 90)
    rstN = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!divOut);
    check(cnt == 91, "R8 first pulse latency", cnt, 91);
    // R3: pulse lasts a single cycle
    @(negedge clk);
    check(!divOut, "R3 pulse width", int'(divOut), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mSet = VECS[i].m; aSet = VECS[i].a;
      preBypass = VECS[i].byp; hardWired = VECS[i].hard;
      measure(per, ms, ps);
      check(per == int'(VECS[i].ratio), $sformatf("R1/R2 ratio vec%0d", i),
            per, int'(VECS[i].ratio));
      check(ms == 11 * int'(VECS[i].aEff), $sformatf("R4 modSel cycles vec%0d", i),
            ms, 11 * int'(VECS[i].aEff));
      check(ps == int'(VECS[i].mEff) + 1, $sformatf("R5 prescaler pulses vec%0d", i),
            ps, int'(VECS[i].mEff) + 1);
    end

    // R6: mid-period change does not truncate the running period
    @(negedge clk);
    mSet = 9'd8; aSet = 4'd0; preBypass = 1'b0; hardWired = 1'b0;
    waitPulse();
    waitPulse();
    per = 1;
    repeat (30) begin @(negedge clk); per++; end
    mSet = 9'd3; aSet = 4'd1;
    while (1) begin
      @(negedge clk);
      if (divOut) break;
      per++;
    end
    check(per == 90, "R6 running period kept", per, 90);
    measure(per, ms, ps);
    check(per == 41, "R6 new ratio next period", per, 41);

    // R3: pulse width after bypass-rate operation
    @(negedge clk);
    preBypass = 1'b1; mSet = 9'd2;
    waitPulse();
    waitPulse();
    @(negedge clk);
    check(!divOut, "R3 pulse width bypass", int'(divOut), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule